// File: doc/BRIEF.md
# Graded Ground-Fault Trip Timer

This block decides when to drive the thyristor gate after a ground fault has been found. Upstream comparators supply four level flags, one for each fault-current band: low (about 6 to 15 mA), medium (15 to 30 mA), high (30 to 100 mA) and very high (above 100 mA). Each band has its own delay, counted in millisecond ticks. A higher band gets a shorter delay. When several flags are set at once, only the timer of the highest band that is set can trip the gate.

While the self-test flag is high, the low band takes an extra delay. The other bands are unaffected. A separate saturation path counts system-clock cycles while the saturation flag stays high. Once that window has elapsed, the path drives the gate, but only while the phase input marks the positive half cycle. The gate output is a single level. After it rises, it stays high until reset.

Top module: `gf_trip_timer`

## Requirements
- R1: After rst_ni is released, gate_o is low while no flag is set and no tick has arrived.
- R2: With only band_low_i set and self_test_i low, gate_o rises one clock after the LOW_MS-th consecutive tick_i pulse (default 150). It stays low after LOW_MS-1 pulses.
- R3: With band_mid_i as the highest flag, gate_o rises one clock after MID_MS ticks (default 40), and not before.
- R4: With band_high_i as the highest flag, gate_o rises one clock after HIGH_MS ticks (default 25), and not before.
- R5: With band_vhigh_i as the highest flag, gate_o rises one clock after VHIGH_MS ticks (default 14), and not before.
- R6: A band's count returns to zero whenever its flag is low for a clock cycle. After that, the full delay must elapse again.
- R7: Only the tick count of the highest band whose flag is set can trip the gate. The order from highest to lowest is vhigh, high, mid, low. A lower band whose own count has already expired does not trip while a higher flag is set.
- R8: While self_test_i is high, the low band trips after LOW_MS+ST_EXTRA_MS ticks (default 250). The medium band still trips after MID_MS.
- R9: The saturation path arms only after sat_i has been high for SAT_CYCLES consecutive clocks (default 2800, which is 1.4 ms at 2 MHz). A low cycle on sat_i restarts the window.
- R10: An armed saturation path raises gate_o only while pos_half_i is high. gate_o rises one clock after pos_half_i goes high.
- R11: Once gate_o is high, it stays high until rst_ni is asserted, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_ms_i | input | 1 | One-cycle pulse every millisecond |
| band_low_i | input | 1 | Low fault band flag |
| band_mid_i | input | 1 | Medium fault band flag |
| band_high_i | input | 1 | High fault band flag |
| band_vhigh_i | input | 1 | Very high fault band flag |
| sat_i | input | 1 | Saturation comparator flag |
| pos_half_i | input | 1 | High during the positive half cycle |
| self_test_i | input | 1 | Self-test in progress |
| gate_o | output | 1 | Thyristor gate enable, latched |

## Verification
Two trip sources can meet in one clock. The very-high band count can expire in the same cycle that an already armed saturation path sees pos_half_i rise. The bench provokes this by arming the saturation window with pos_half_i low. It then brings the band count to its limit with one tick and raises pos_half_i at the next falling edge, so both trip conditions are true before the same rising edge. The result is judged by gate_o rising exactly once and then holding through a later drop of every input.

// File: rtl/gft_pkg.sv
package gft_pkg;

  localparam int NUM_BANDS = 4;

  // index order doubles as priority: higher index wins
  typedef enum logic [2:0] {
    BAND_NONE  = 3'd0,
    BAND_LOW   = 3'd1,
    BAND_MID   = 3'd2,
    BAND_HIGH  = 3'd3,
    BAND_VHIGH = 3'd4
  } band_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gft_band_sel.sv
module gft_band_sel
  import gft_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANDS-1:0] flags_i,
  output band_e                band_o,
  output logic [NUM_BANDS-1:0] sel_o
);

  always_comb begin
    band_o = BAND_NONE;
    sel_o  = '0;
    for (int i = 0; i < NUM_BANDS; i++) begin
      if (flags_i[i]) begin
        band_o = band_e'(i + 1);
        sel_o  = '0;
        sel_o[i] = 1'b1;
      end
    end
  end

  assert_sel_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_o) && ((flags_i == '0) == (sel_o == '0)));

  assert_top_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_i[NUM_BANDS-1] |-> sel_o[NUM_BANDS-1]);

endmodule

// File: rtl/gft_band_timer.sv
module gft_band_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!active_i)                 cnt_q <= '0;
    else if (tick_i && (cnt_q != '1))   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = active_i && (cnt_q >= limit_i);

  assert_restart_on_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));

  assert_hold_without_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/gft_sat_path.sv
module gft_sat_path #(
  parameter int SAT_CYCLES = 2800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sat_i,
  input  logic pos_half_i,
  output logic armed_o,
  output logic fire_o
);

  localparam int SW = $clog2(SAT_CYCLES + 1);
  localparam logic [SW-1:0] SAT_LIM = SW'(SAT_CYCLES);

  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!sat_i)             cnt_q <= '0;
    else if (cnt_q != SAT_LIM)   cnt_q <= cnt_q + 1'b1;
  end

  assign armed_o = sat_i && (cnt_q == SAT_LIM);
  assign fire_o  = armed_o && pos_half_i;

  assert_arm_needs_persist_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> $past(sat_i));

  assert_drop_disarms_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sat_i |=> !armed_o);

endmodule

// File: rtl/gf_trip_timer.sv
module gf_trip_timer
  import gft_pkg::*;
#(
  parameter int LOW_MS      = 150,
  parameter int MID_MS      = 40,
  parameter int HIGH_MS     = 25,
  parameter int VHIGH_MS    = 14,
  parameter int ST_EXTRA_MS = 100,
  parameter int SAT_CYCLES  = 2800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_ms_i,
  input  logic band_low_i,
  input  logic band_mid_i,
  input  logic band_high_i,
  input  logic band_vhigh_i,
  input  logic sat_i,
  input  logic pos_half_i,
  input  logic self_test_i,
  output logic gate_o
);

  localparam int MAX_LIM = max_of(max_of(LOW_MS + ST_EXTRA_MS, MID_MS),
                                  max_of(HIGH_MS, VHIGH_MS));
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic [NUM_BANDS-1:0] flags, sel, expired;
  logic [CNT_W-1:0]     limit [NUM_BANDS];
  band_e                band;
  logic                 band_fire, sat_armed, sat_fire, gate_q;

  assign flags = {band_vhigh_i, band_high_i, band_mid_i, band_low_i};

  always_comb begin
    limit[0] = self_test_i ? CNT_W'(LOW_MS + ST_EXTRA_MS) : CNT_W'(LOW_MS);
    limit[1] = CNT_W'(MID_MS);
    limit[2] = CNT_W'(HIGH_MS);
    limit[3] = CNT_W'(VHIGH_MS);
  end

  gft_band_sel i_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flags_i (flags),
    .band_o  (band),
    .sel_o   (sel)
  );

  for (genvar g = 0; g < NUM_BANDS; g++) begin : g_band
    gft_band_timer #(.CNT_W(CNT_W)) i_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick_ms_i),
      .active_i  (flags[g]),
      .limit_i   (limit[g]),
      .expired_o (expired[g])
    );
  end

  gft_sat_path #(.SAT_CYCLES(SAT_CYCLES)) i_sat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sat_i      (sat_i),
    .pos_half_i (pos_half_i),
    .armed_o    (sat_armed),
    .fire_o     (sat_fire)
  );

  // only the selected (highest) band may trip
  assign band_fire = |(expired & sel);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      gate_q <= 1'b0;
    else if (band_fire || sat_fire)   gate_q <= 1'b1;
  end

  assign gate_o = gate_q;

  assert_gate_latched_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |=> gate_o);

  assert_gate_has_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(band_fire || sat_fire));

  assert_sat_phase_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sat_fire && !band_fire) |-> pos_half_i);

  assert_band_known_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (band == BAND_NONE) |-> !band_fire);

endmodule

// File: tb/test_gf_trip_timer.sv
module test_gf_trip_timer;

  localparam int LOW = 15, MID = 8, HIGH = 5, VH = 3, EXTRA = 10, SAT = 20;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic f_low = 0, f_mid = 0, f_high = 0, f_vh = 0, sat = 0, pos = 0, st = 0;
  logic gate;
  int   total = 0, bad = 0;
  bit   done = 0;

  always #10 clk = ~clk;

  gf_trip_timer #(.LOW_MS(LOW), .MID_MS(MID), .HIGH_MS(HIGH), .VHIGH_MS(VH),
                  .ST_EXTRA_MS(EXTRA), .SAT_CYCLES(SAT)) i_gf_trip_timer (
    .clk_i(clk), .rst_ni(rst_n), .tick_ms_i(tick),
    .band_low_i(f_low), .band_mid_i(f_mid), .band_high_i(f_high), .band_vhigh_i(f_vh),
    .sat_i(sat), .pos_half_i(pos), .self_test_i(st), .gate_o(gate));

  task automatic check(input logic exp, input string req, input string what);
    total++;
    if (gate !== exp) begin
      bad++;
      $display("FAIL %s %s: gate_o=%b expected %b", req, what, gate, exp);
    end
  endtask

  task automatic do_reset();
    {f_low, f_mid, f_high, f_vh, sat, pos, st, tick} = '0;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    repeat (4) @(negedge clk);
    check(1'b0, "R1", "idle after reset");
  endtask

  task automatic t_band(input int which, input int lim, input string req);
    do_reset();
    case (which)
      0: f_low = 1; 1: f_mid = 1; 2: f_high = 1; default: f_vh = 1;
    endcase
    ticks(lim - 1);
    check(1'b0, req, "one tick short");
    ticks(1);
    check(1'b1, req, "at limit");
  endtask

  task automatic t_restart();
    do_reset();
    f_low = 1;
    ticks(LOW - 1);
    f_low = 0;
    @(negedge clk) f_low = 1;
    ticks(LOW - 1);
    check(1'b0, "R6", "count restarted after drop");
    ticks(1);
    check(1'b1, "R6", "full delay after restart");
  endtask

  task automatic t_priority();
    do_reset();
    f_low = 1;
    ticks(LOW - 1);
    f_mid = 1;
    ticks(1);
    check(1'b0, "R7", "expired low masked by mid");
    ticks(MID - 2);
    check(1'b0, "R7", "mid one short");
    ticks(1);
    check(1'b1, "R7", "mid trips with low set");
  endtask

  task automatic t_selftest();
    do_reset();
    st = 1; f_low = 1;
    ticks(LOW);
    check(1'b0, "R8", "low delayed in self-test");
    ticks(EXTRA - 1);
    check(1'b0, "R8", "extra one short");
    ticks(1);
    check(1'b1, "R8", "low trips after extra");
    do_reset();
    st = 1; f_mid = 1;
    ticks(MID);
    check(1'b1, "R8", "mid unaffected by self-test");
  endtask

  task automatic t_sat_persist();
    do_reset();
    pos = 1;
    @(negedge clk) sat = 1;
    repeat (SAT - 1) @(negedge clk);
    sat = 0;
    repeat (4) @(negedge clk);
    check(1'b0, "R9", "short saturation ignored");
    sat = 1;
    repeat (SAT + 3) @(negedge clk);
    check(1'b1, "R9", "persistent saturation trips");
  endtask

  task automatic t_sat_phase();
    do_reset();
    sat = 1;
    repeat (SAT + 6) @(negedge clk);
    check(1'b0, "R10", "armed, negative half");
    pos = 1;
    @(negedge clk);
    check(1'b1, "R10", "fires one clock after positive half");
  endtask

  task automatic t_latch();
    do_reset();
    f_high = 1;
    ticks(HIGH);
    {f_high, pos, sat} = '0;
    ticks(4);
    check(1'b1, "R11", "held after inputs drop");
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R11", "cleared by reset");
    rst_n = 1'b1;
  endtask

  task automatic t_coincide();
    do_reset();
    sat = 1; f_vh = 1;
    repeat (SAT + 2) @(negedge clk);
    ticks(VH - 1);
    check(1'b0, "R5", "both pending");
    @(negedge clk) tick = 1'b1;
    @(negedge clk) begin tick = 1'b0; pos = 1'b1; end
    check(1'b0, "R10", "before shared edge");
    @(negedge clk);
    check(1'b1, "R5", "band and saturation same cycle");
    {sat, f_vh, pos} = '0;
    ticks(3);
    check(1'b1, "R11", "held after coincident trip");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_band(0, LOW, "R2");
    t_band(1, MID, "R3");
    t_band(2, HIGH, "R4");
    t_band(3, VH, "R5");
    t_restart();
    t_priority();
    t_selftest();
    t_sat_persist();
    t_sat_phase();
    t_latch();
    t_coincide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule